// File: doc/BRIEF.md
# Zero-Cross Synchronized Phase-Angle Timer

This block times the firing point of an AC power regulator within each mains half-cycle. A zero-cross detector drives `zc_in`. Each qualified zero-cross edge starts a timing cycle of 1024 counts. The gate output turns on once the count reaches a programmed compare value, and it stays on until the cycle ends. A small compare value fires early in the half-cycle and delivers more power. A large value fires late and delivers less.

The zero-cross input first passes through a two-stage synchronizer. An optional noise filter follows, which needs four equal samples in a row before its output changes. An edge detector comes last, and its polarity is selectable. When a cycle ends, the timer drops the gate and waits for the next trigger. A trigger that arrives while a cycle is still running restarts the count.

Software writes a new compare value into a holding register. That value only becomes active after a commit strobe, and only at the start of the following cycle, so a firing pulse is never cut short. A one-clock done pulse marks the moment the new value is applied.

Top module: `phase_angle_timer`

## Requirements
- R1: While reset is high and after it is released, `gate_out` and `sync_done` are low. The timer stays idle and does not count until the first qualified trigger arrives. The active compare value resets to 1023 (off).
- R2: `edge_rise` selects the active edge: 1 selects a rising edge of `zc_in` and 0 selects a falling edge. With the filter off, an edge of `zc_in` set up before clock edge k starts a cycle at clock edge k+2, when the count is 0.
- R3: With `filt_en` high, the synchronized input changes its filtered value only after four consecutive equal samples. This delays the cycle start by four clocks, to edge k+6. A pulse shorter than four clocks starts no cycle.
- R4: The count runs 0 to 1023, one step per clock. The clock edge after count 1023 ends the cycle: the timer returns to idle with the gate low until the next trigger.
- R5: While a cycle runs, `gate_out` is high exactly when the count is greater than or equal to the active compare value.
- R6: An active compare value of 0 keeps `gate_out` high for all 1024 counts of the cycle. A value of 1023 keeps it low for the whole cycle.
- R7: A trigger that arrives while a cycle is running restarts the count at 0 on the next clock edge. The gate follows the restarted count.
- R8: A value written with `cmp_wr_en` becomes active only after a `cmp_sync` strobe, at the next cycle start. At that same start, `sync_done` is high for exactly one clock, while the count is 0.
- R9: Compare writes without a commit strobe leave the active value unchanged across later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Asynchronous zero-cross trigger |
| filt_en | input | 1 | 1 enables the four-sample noise filter |
| edge_rise | input | 1 | 1 = rising edge active, 0 = falling edge active |
| cmp_wr_en | input | 1 | Loads `cmp_wr_data` into the holding register |
| cmp_wr_data | input | 10 | New firing compare value |
| cmp_sync | input | 1 | Commit strobe for the held compare value |
| gate_out | output | 1 | Firing output, high while the gate is on |
| sync_done | output | 1 | One-clock pulse when a held value is applied |

## Verification
The properties assume that `filt_en` and `edge_rise` change only while no zero-cross edge is in flight, and that the commit and write strobes last one clock each. The stimulus changes every input on the falling clock edge. It switches the filter and the edge polarity only while `zc_in` sits at its idle level. Triggers are spaced widely enough that the edge detector never sees a level change caused by reconfiguration.

// File: rtl/phase_timer_pkg.sv
package phase_timer_pkg;

    localparam int CNT_W = 10;
    localparam logic [CNT_W-1:0] CNT_END = '1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] held;
        logic [CNT_W-1:0] live;
        logic             armed;
    } cmp_bank_t;

    // Firing decision: on from the compare point, never on for the end value
    function automatic logic fire_level(input logic running,
                                        input logic [CNT_W-1:0] count,
                                        input logic [CNT_W-1:0] point);
        return running && (point != CNT_END) && (count >= point);
    endfunction

endpackage

// File: rtl/zc_conditioner.sv
module zc_conditioner
    import phase_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic zc_in,
    input  logic filt_en,
    input  logic edge_rise,
    output logic trig
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [FILT_LEN-2:0]    hist_q;
    logic [FILT_LEN-1:0]    window;
    logic                   filt_q;
    logic                   qual;
    logic                   qual_d;

    assign synced = sync_q[SYNC_STAGES-1];
    assign window = {hist_q, synced};
    assign qual   = filt_en ? filt_q : synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            filt_q <= 1'b0;
            qual_d <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], zc_in};
            hist_q <= window[FILT_LEN-2:0];
            if (&window)
                filt_q <= 1'b1;
            else if (~|window)
                filt_q <= 1'b0;
            qual_d <= qual;
        end
    end

    assign trig = edge_rise ? (qual & ~qual_d) : (~qual & qual_d);

endmodule

// File: rtl/cmp_buffer.sv
module cmp_buffer
    import phase_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sync_req,
    input  logic             cycle_start,
    output logic [CNT_W-1:0] live_cmp,
    output logic             applied
);

    cmp_bank_t bank_q;
    logic      commit;

    assign commit = cycle_start && (bank_q.armed || sync_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q.held  <= CNT_END;
            bank_q.live  <= CNT_END;
            bank_q.armed <= 1'b0;
            applied      <= 1'b0;
        end else begin
            applied <= commit;
            if (wr_en)
                bank_q.held <= wr_data;
            if (commit) begin
                bank_q.live  <= bank_q.held;
                bank_q.armed <= 1'b0;
            end else if (sync_req) begin
                bank_q.armed <= 1'b1;
            end
        end
    end

    assign live_cmp = bank_q.live;

endmodule

// File: rtl/phase_counter.sv
module phase_counter
    import phase_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    output logic             running,
    output logic [CNT_W-1:0] count
);

    run_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            count   <= '0;
        end else if (trig) begin
            state_q <= ST_RUN;
            count   <= '0;
        end else if (state_q == ST_RUN) begin
            if (count == CNT_END) begin
                state_q <= ST_IDLE;
                count   <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    assign running = (state_q == ST_RUN);

endmodule

// File: rtl/phase_angle_timer.sv
module phase_angle_timer
    import phase_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_in,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             cmp_sync,
    output logic             gate_out,
    output logic             sync_done
);

    logic             trig;
    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_cmp;

    zc_conditioner #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_cond (
        .clk       (clk),
        .rst       (rst),
        .zc_in     (zc_in),
        .filt_en   (filt_en),
        .edge_rise (edge_rise),
        .trig      (trig)
    );

    cmp_buffer u_cmp (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cmp_wr_en),
        .wr_data     (cmp_wr_data),
        .sync_req    (cmp_sync),
        .cycle_start (trig),
        .live_cmp    (act_cmp),
        .applied     (sync_done)
    );

    phase_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .running (running),
        .count   (cnt)
    );

    assign gate_out = fire_level(running, cnt, act_cmp);

endmodule

// File: rtl/phase_timer_chk.sv
module phase_timer_chk
    import phase_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             trig,
    input logic             running,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_cmp,
    input logic             gate_out,
    input logic             sync_done
);

    assert_idle_gate_low_R1: assert property (@(posedge clk) disable iff (rst)
        !running |-> !gate_out);

    assert_cycle_end_R4: assert property (@(posedge clk) disable iff (rst)
        (running && cnt == CNT_END && !trig) |=> (!running && !gate_out));

    assert_gate_rise_point_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_out) |-> (cnt == act_cmp));

    assert_full_on_R6: assert property (@(posedge clk) disable iff (rst)
        (running && act_cmp == '0) |-> gate_out);

    assert_full_off_R6: assert property (@(posedge clk) disable iff (rst)
        (act_cmp == CNT_END) |-> !gate_out);

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        trig |=> (running && cnt == '0));

    assert_done_at_start_R8: assert property (@(posedge clk) disable iff (rst)
        sync_done |-> (running && cnt == '0));

    assert_cmp_held_R9: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(act_cmp));

endmodule

bind phase_angle_timer phase_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .running   (running),
    .cnt       (cnt),
    .act_cmp   (act_cmp),
    .gate_out  (gate_out),
    .sync_done (sync_done)
);

// File: tb/phase_angle_timer_test.sv
module phase_angle_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_in = 1'b0;
    logic       filt_en = 1'b0;
    logic       edge_rise = 1'b1;
    logic       cmp_wr_en = 1'b0;
    logic [9:0] cmp_wr_data = '0;
    logic       cmp_sync = 1'b0;
    logic       gate_out;
    logic       sync_done;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    finished = 0;

    always #5 clk = ~clk;

    phase_angle_timer uut (
        .clk         (clk),
        .rst         (rst),
        .zc_in       (zc_in),
        .filt_en     (filt_en),
        .edge_rise   (edge_rise),
        .cmp_wr_en   (cmp_wr_en),
        .cmp_wr_data (cmp_wr_data),
        .cmp_sync    (cmp_sync),
        .gate_out    (gate_out),
        .sync_done   (sync_done)
    );

    // Behavioural reference model, advanced once per rising edge
    bit m_s1, m_s2, m_filt, m_prevq, m_run, m_armed, m_done;
    bit m_win[$];
    int m_cnt, m_pend, m_act;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_filt = 0; m_prevq = 0;
            m_run = 0; m_armed = 0; m_done = 0;
            m_cnt = 0; m_pend = 1023; m_act = 1023;
            m_win = '{0, 0, 0};
        end else begin
            bit q, t, ones, zeros;
            q = filt_en ? m_filt : m_s2;
            t = edge_rise ? (q && !m_prevq) : (!q && m_prevq);
            m_done = 0;
            if (t && (m_armed || cmp_sync)) begin
                m_act = m_pend; m_armed = 0; m_done = 1;
            end else if (cmp_sync) begin
                m_armed = 1;
            end
            if (cmp_wr_en) m_pend = int'(cmp_wr_data);
            if (t) begin
                m_run = 1; m_cnt = 0;
            end else if (m_run) begin
                if (m_cnt == 1023) begin m_run = 0; m_cnt = 0; end
                else m_cnt++;
            end
            m_prevq = q;
            m_win.push_back(m_s2);
            ones = 1; zeros = 1;
            foreach (m_win[i]) begin
                if (m_win[i]) zeros = 0; else ones = 0;
            end
            if (ones) m_filt = 1;
            else if (zeros) m_filt = 0;
            void'(m_win.pop_front());
            m_s2 = m_s1; m_s1 = zc_in;
        end
    end

    function automatic bit exp_gate();
        return m_run && (m_act != 1023) && (m_cnt >= m_act);
    endfunction

    always @(negedge clk) begin
        if (!finished) begin
            n_checks++;
            if (gate_out !== exp_gate()) begin
                n_fails++;
                $display("FAIL %s gate_out actual=%b expected=%b at %0t", cur_req, gate_out, exp_gate(), $time);
            end
            n_checks++;
            if (sync_done !== (rst ? 1'b0 : m_done)) begin
                n_fails++;
                $display("FAIL %s sync_done actual=%b expected=%b at %0t", cur_req, sync_done, m_done, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_zc(input bit lvl, input int len);
        zc_in = lvl;
        tick(len);
        zc_in = !lvl;
    endtask

    task automatic write_cmp(input int v, input bit commit);
        cmp_wr_en = 1'b1;
        cmp_wr_data = 10'(v);
        tick(1);
        cmp_wr_en = 1'b0;
        if (commit) begin
            cmp_sync = 1'b1;
            tick(1);
            cmp_sync = 1'b0;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state and idle until first trigger
        cur_req = "R1";
        tick(5);
        rst = 1'b0;
        tick(30);

        // R8: commit applies at the next cycle start; R4/R5 over a full cycle
        cur_req = "R8";
        write_cmp(500, 1);
        tick(20);
        cur_req = "R5";
        pulse_zc(1'b1, 6);
        tick(1100);

        // R7: restart while running
        cur_req = "R7";
        write_cmp(300, 1);
        pulse_zc(1'b1, 6);
        tick(700);
        pulse_zc(1'b1, 6);
        tick(1100);

        // R6: full-on and full-off cycles
        cur_req = "R6";
        write_cmp(0, 1);
        pulse_zc(1'b1, 6);
        tick(1100);
        write_cmp(1023, 1);
        pulse_zc(1'b1, 6);
        tick(1100);

        // R9: a write without commit leaves the active value alone
        cur_req = "R9";
        write_cmp(600, 1);
        pulse_zc(1'b1, 6);
        tick(1100);
        write_cmp(100, 0);
        pulse_zc(1'b1, 6);
        tick(1100);
        pulse_zc(1'b1, 6);
        tick(1100);

        // R3: filtered input, a short glitch is ignored
        cur_req = "R3";
        filt_en = 1'b1;
        tick(10);
        write_cmp(200, 1);
        pulse_zc(1'b1, 2);
        tick(50);
        pulse_zc(1'b1, 8);
        tick(1100);

        // R2: falling-edge trigger, filter off
        cur_req = "R2";
        filt_en = 1'b0;
        zc_in = 1'b1;
        tick(10);
        edge_rise = 1'b0;
        tick(10);
        write_cmp(800, 1);
        pulse_zc(1'b0, 6);
        tick(1100);

        // R4: idle after the cycle end
        cur_req = "R4";
        tick(50);
        finish_run();
    end

endmodule